// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block powers up four regulators one at a time. A mode input picks one of six fixed enable orders. For each rail in turn, the block raises that rail's enable and waits a ramp delay set for that rail. It then samples the rail's power-good input. If the rail is good, the block waits a separate slot delay for that rail and then moves on to the next rail. When the slot delay of the last rail expires, the sequence is complete and the block reports done.

All delays are counted in milliseconds on a 50 kHz tick input, at 50 ticks per millisecond. Each rail has its own ramp value and its own slot value. A value of zero is raised to 1 ms, and a value above 1300 is lowered to 1300 ms.

The block shuts every rail down at once in two cases: a rail is not good when it is checked, or a bit of the runtime fault vector is set. It then holds a fail flag and the number of the rail that failed. A restart request is accepted only while the block has failed. It turns all four regulators back on together, without sequencing.

Top module: `pwrseq_top`

## Requirements
- R1: After reset is released, sequencing starts without any request. The mode is captured on the first clock edge. The first enable rises on the second edge. Changing the mode after that has no effect until the next reset. During reset, rail_en, done and fail are all low.
- R2: Enable orders by mode value, with rail numbers matching rail_en bit positions: 1 gives 0,1,2,3; 2 gives 3,2,1,0; 3 gives 0,2,1,3; 4 gives 1,0,3,2; 5 gives 2,3,0,1; 6 gives 3,0,1,2. Mode values 0 and 7 give the order of mode 1.
- R3: Each enable step adds exactly one rail. The next rail is not enabled until the current rail has been found good.
- R4: With tick high on every cycle, a rail's power-good is sampled ramp×50+1 cycles after its enable rises. The next rail's enable rises (ramp+slot)×50+3 cycles after the previous rail's enable.
- R5: Delays advance only on cycles where tick is high. While tick is low, timing stops and the enables do not change.
- R6: A delay value of 0 counts as 1 ms. A delay value above 1300 counts as 1300 ms.
- R7: done rises (ramp+slot)×50+2 cycles after the last rail's enable. At that point all four enables are high and busy is low.
- R8: If a rail's power-good is low when it is sampled, all enables drop on the same edge. fail goes high, fail_rail shows that rail's number, and busy and done are low.
- R9: If any fault bit is set on an edge while the block is not failed, the next edge drops all enables and sets fail. fail_rail then shows the lowest-numbered fault bit that was set.
- R10: fail and fail_rail hold until a restart request. On the edge after a restart request, all four enables rise together, done goes high, fail clears and fail_rail goes to 0.
- R11: A restart request while sequencing or while done has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 50 kHz time-base strobe, one cycle wide |
| pgood | input | 4 | Power-good status for each rail |
| fault | input | 4 | Runtime fault for each rail |
| mode | input | 3 | Order select, 1 to 6 |
| ramp_ms | input | 48 | Ramp delay in ms for each rail, 12 bits per rail, rail 0 in the low bits |
| slot_ms | input | 48 | Slot delay in ms for each rail, same packing as ramp_ms |
| restart | input | 1 | Restart request after a failure |
| rail_en | output | 4 | Regulator enables |
| busy | output | 1 | Sequencing in progress |
| done | output | 1 | All rails are on |
| fail | output | 1 | Latched failure |
| fail_rail | output | 2 | Number of the rail that failed |

## Verification
The bench keeps a free-running edge count and samples every output on the falling edge, between two rising edges. For each rail it records the edge on which the enable first appears, and it does the same for done and for fail. The measured spacings are compared with arithmetic results: the first enable two edges after reset is released, (ramp+slot)×50+3 between successive enables, +2 for done, and ramp×50+1 for a power-good failure. Fault responses, restart responses and ignored restarts are each checked on the very next falling edge after the edge that sampled them. The stall test holds tick low for a fixed number of edges and expects the enable spacing to grow by exactly that number.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   localparam int NRAIL  = 4;
   localparam int RIDX_W = 2;
   localparam int MODE_W = 3;

   typedef logic [RIDX_W-1:0] rail_idx_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ENABLE,
      S_RAMP,
      S_SLOT,
      S_DONE,
      S_FAIL
   } seq_state_t;
endpackage

// File: rtl/pwrseq_order.sv
module pwrseq_order
   import pwrseq_pkg::*;
(
   input  logic [MODE_W-1:0]             mode,
   output logic [NRAIL-1:0][RIDX_W-1:0]  order
);
   function automatic logic [NRAIL-1:0][RIDX_W-1:0] seq4(input int a, input int b,
                                                          input int c, input int d);
      logic [NRAIL-1:0][RIDX_W-1:0] r;
      r[0] = rail_idx_t'(a);
      r[1] = rail_idx_t'(b);
      r[2] = rail_idx_t'(c);
      r[3] = rail_idx_t'(d);
      return r;
   endfunction

   always_comb begin
      case (mode)
         3'd2:    order = seq4(3, 2, 1, 0);
         3'd3:    order = seq4(0, 2, 1, 3);
         3'd4:    order = seq4(1, 0, 3, 2);
         3'd5:    order = seq4(2, 3, 0, 1);
         3'd6:    order = seq4(3, 0, 1, 2);
         default: order = seq4(0, 1, 2, 3);
      endcase
   end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
   parameter int TICKS_PER_MS = 50,
   parameter int MAX_MS       = 1300,
   parameter int DLY_W        = 12,
   parameter bit TWO_STAGE    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [DLY_W-1:0] ms_i,
   output logic             expired
);
   localparam int MS_W  = $clog2(MAX_MS + 1);
   localparam int CNT_W = $clog2(MAX_MS * TICKS_PER_MS + 1);
   localparam int SUB_W = $clog2(TICKS_PER_MS + 1);

   initial begin
      if (DLY_W < MS_W) $fatal(1, "delay field narrower than the clamp limit");
      if (TICKS_PER_MS < 1) $fatal(1, "ticks per millisecond must be positive");
      if (MAX_MS < 1) $fatal(1, "maximum delay must be positive");
   end

   logic [MS_W-1:0] ms_c;

   always_comb begin
      if (ms_i == '0)
         ms_c = MS_W'(1);
      else if (ms_i > DLY_W'(MAX_MS))
         ms_c = MS_W'(MAX_MS);
      else
         ms_c = ms_i[MS_W-1:0];
   end

   if (TWO_STAGE) begin : g_two_stage
      logic [MS_W-1:0]  ms_cnt;
      logic [SUB_W-1:0] sub;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ms_cnt <= '0;
            sub    <= '0;
         end else if (load) begin
            ms_cnt <= ms_c;
            sub    <= SUB_W'(TICKS_PER_MS - 1);
         end else if (tick && ms_cnt != '0) begin
            if (sub == '0) begin
               sub    <= SUB_W'(TICKS_PER_MS - 1);
               ms_cnt <= ms_cnt - MS_W'(1);
            end else begin
               sub <= sub - SUB_W'(1);
            end
         end
      end

      assign expired = (ms_cnt == '0);

      // R5
      ms_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!load && !tick) |=> ($stable(ms_cnt) && $stable(sub)));

      // R4
      ms_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!load) |=> (ms_cnt <= $past(ms_cnt)));
   end else begin : g_flat
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (load)
            cnt <= CNT_W'(ms_c) * CNT_W'(TICKS_PER_MS);
         else if (tick && cnt != '0)
            cnt <= cnt - CNT_W'(1);
      end

      assign expired = (cnt == '0);

      // R5
      cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!load && !tick) |=> $stable(cnt));

      // R4
      cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!load) |=> (cnt <= $past(cnt)));
   end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
   import pwrseq_pkg::*;
#(
   parameter int TICKS_PER_MS    = 50,
   parameter int MAX_MS          = 1300,
   parameter int DLY_W           = 12,
   parameter bit TWO_STAGE_TIMER = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [NRAIL-1:0]        pgood,
   input  logic [NRAIL-1:0]        fault,
   input  logic [MODE_W-1:0]       mode,
   input  logic [NRAIL*DLY_W-1:0]  ramp_ms,
   input  logic [NRAIL*DLY_W-1:0]  slot_ms,
   input  logic                    restart,
   output logic [NRAIL-1:0]        rail_en,
   output logic                    busy,
   output logic                    done,
   output logic                    fail,
   output logic [RIDX_W-1:0]       fail_rail
);
   seq_state_t                    state;
   rail_idx_t                     step;
   logic [MODE_W-1:0]             mode_q;
   logic [NRAIL-1:0][RIDX_W-1:0]  order;
   rail_idx_t                     cur_rail;
   rail_idx_t                     fault_idx;
   logic                          fault_any;
   logic [DLY_W-1:0]              ramp_a [NRAIL];
   logic [DLY_W-1:0]              slot_a [NRAIL];
   logic [DLY_W-1:0]              tmr_ms;
   logic                          tmr_load;
   logic                          tmr_exp;

   for (genvar g = 0; g < NRAIL; g++) begin : g_unpack
      assign ramp_a[g] = ramp_ms[g*DLY_W +: DLY_W];
      assign slot_a[g] = slot_ms[g*DLY_W +: DLY_W];
   end

   pwrseq_order order_i (
      .mode  (mode_q),
      .order (order)
   );

   assign cur_rail = order[step];
   assign tmr_ms   = (state == S_ENABLE) ? ramp_a[cur_rail] : slot_a[cur_rail];
   assign tmr_load = (state == S_ENABLE) || (state == S_RAMP && tmr_exp);

   pwrseq_timer #(
      .TICKS_PER_MS (TICKS_PER_MS),
      .MAX_MS       (MAX_MS),
      .DLY_W        (DLY_W),
      .TWO_STAGE    (TWO_STAGE_TIMER)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .load    (tmr_load),
      .ms_i    (tmr_ms),
      .expired (tmr_exp)
   );

   assign fault_any = |fault;

   always_comb begin
      fault_idx = '0;
      for (int i = NRAIL - 1; i >= 0; i--)
         if (fault[i]) fault_idx = rail_idx_t'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         step      <= '0;
         mode_q    <= '0;
         rail_en   <= '0;
         fail      <= 1'b0;
         fail_rail <= '0;
      end else if (state != S_FAIL && fault_any) begin
         rail_en   <= '0;
         fail      <= 1'b1;
         fail_rail <= fault_idx;
         state     <= S_FAIL;
      end else begin
         case (state)
            S_IDLE: begin
               mode_q <= mode;
               step   <= '0;
               state  <= S_ENABLE;
            end
            S_ENABLE: begin
               rail_en[cur_rail] <= 1'b1;
               state             <= S_RAMP;
            end
            S_RAMP: begin
               if (tmr_exp) begin
                  if (pgood[cur_rail]) begin
                     state <= S_SLOT;
                  end else begin
                     rail_en   <= '0;
                     fail      <= 1'b1;
                     fail_rail <= cur_rail;
                     state     <= S_FAIL;
                  end
               end
            end
            S_SLOT: begin
               if (tmr_exp) begin
                  if (step == rail_idx_t'(NRAIL - 1)) begin
                     state <= S_DONE;
                  end else begin
                     step  <= step + rail_idx_t'(1);
                     state <= S_ENABLE;
                  end
               end
            end
            S_FAIL: begin
               if (restart) begin
                  rail_en   <= '1;
                  fail      <= 1'b0;
                  fail_rail <= '0;
                  state     <= S_DONE;
               end
            end
            default: ;
         endcase
      end
   end

   assign busy = (state == S_IDLE) || (state == S_ENABLE) ||
                 (state == S_RAMP) || (state == S_SLOT);
   assign done = (state == S_DONE);

   // R3
   en_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($countones(rail_en & ~$past(rail_en)) <= 1));

   // R8
   en_off_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (rail_en == '0 && !busy && !done));

   // R10
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !restart) |=> (fail && $stable(fail_rail)));

   // R7
   all_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rail_en == '1 && !fail));
endmodule

// File: tb/pwrseq_top_tb_top.sv
module pwrseq_top_tb_top;
   localparam int DW  = 12;
   localparam int TPM = 50;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b1;
   logic [3:0]    pgood = 4'hF;
   logic [3:0]    fault = 4'h0;
   logic [2:0]    mode = 3'd1;
   logic [4*DW-1:0] ramp_ms = '0;
   logic [4*DW-1:0] slot_ms = '0;
   logic          restart = 1'b0;
   logic [3:0]    rail_en;
   logic          busy;
   logic          done;
   logic          fail;
   logic [1:0]    fail_rail;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int t_rel = 0;
   int rv [4];
   int sv [4];

   int t_en [4];
   int ord_seen [4];
   bit seen [4];
   int n_seen;
   int t_done;
   int t_fail;

   pwrseq_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .pgood     (pgood),
      .fault     (fault),
      .mode      (mode),
      .ramp_ms   (ramp_ms),
      .slot_ms   (slot_ms),
      .restart   (restart),
      .rail_en   (rail_en),
      .busy      (busy),
      .done      (done),
      .fail      (fail),
      .fail_rail (fail_rail)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!rst_n) begin
         n_seen = 0;
         t_done = -1;
         t_fail = -1;
         for (int i = 0; i < 4; i++) seen[i] = 1'b0;
      end else begin
         for (int i = 0; i < 4; i++) begin
            if (rail_en[i] && !seen[i]) begin
               seen[i] = 1'b1;
               t_en[i] = cyc;
               if (n_seen < 4) ord_seen[n_seen] = i;
               n_seen++;
            end
         end
         if (done && t_done < 0) t_done = cyc;
         if (fail && t_fail < 0) t_fail = cyc;
      end
   end

   function automatic int clamp_ms(input int v);
      if (v == 0) return 1;
      if (v > 1300) return 1300;
      return v;
   endfunction

   function automatic int ticks(input int v);
      return clamp_ms(v) * TPM;
   endfunction

   function automatic int exp_rail(input int m, input int s);
      int mm;
      int r;
      mm = (m >= 1 && m <= 6) ? m : 1;
      r = 0;
      case (mm)
         1: r = s;
         2: r = 3 - s;
         3: case (s) 0: r = 0; 1: r = 2; 2: r = 1; default: r = 3; endcase
         4: case (s) 0: r = 1; 1: r = 0; 2: r = 3; default: r = 2; endcase
         5: r = (s + 2) % 4;
         default: r = (s + 3) % 4;
      endcase
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step_n();
      @(negedge clk);
      #1;
   endtask

   task automatic pack_delays();
      for (int i = 0; i < 4; i++) begin
         ramp_ms[i*DW +: DW] = DW'(rv[i]);
         slot_ms[i*DW +: DW] = DW'(sv[i]);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) step_n();
      rst_n = 1'b1;
      t_rel = cyc;
   endtask

   task automatic wait_end();
      for (int k = 0; k < 70000; k++) begin
         if (done || fail) break;
         step_n();
      end
   endtask

   task automatic wait_first();
      for (int k = 0; k < 20; k++) begin
         if (n_seen >= 1) break;
         step_n();
      end
   endtask

   task automatic check_good_run(input int m);
      int r;
      int q;
      chk(n_seen == 4, "R3 enable count", n_seen, 4);
      for (int s = 0; s < 4; s++)
         chk(ord_seen[s] == exp_rail(m, s), "R2 order step", ord_seen[s], exp_rail(m, s));
      r = exp_rail(m, 0);
      chk(t_en[r] == t_rel + 2, "R1 first enable edge", t_en[r] - t_rel, 2);
      for (int s = 0; s < 3; s++) begin
         r = exp_rail(m, s);
         q = exp_rail(m, s + 1);
         chk(t_en[q] - t_en[r] == ticks(rv[r]) + ticks(sv[r]) + 3, "R4 enable spacing",
             t_en[q] - t_en[r], ticks(rv[r]) + ticks(sv[r]) + 3);
      end
      r = exp_rail(m, 3);
      chk(t_done - t_en[r] == ticks(rv[r]) + ticks(sv[r]) + 2, "R7 done timing",
          t_done - t_en[r], ticks(rv[r]) + ticks(sv[r]) + 2);
      chk(rail_en == 4'hF && !busy && !fail, "R7 final state", int'(rail_en), 15);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin rv[i] = 1; sv[i] = 1; end
      pack_delays();
      repeat (2) step_n();
      chk(rail_en == 4'h0 && !done && !fail, "R1 reset state", int'(rail_en), 0);

      // R2, R4, R7: every mode value with per-rail delays
      for (int m = 0; m < 8; m++) begin
         mode = 3'(m);
         for (int i = 0; i < 4; i++) begin
            rv[i] = 1 + ((m + i) % 2);
            sv[i] = 1 + ((m + 2 * i) % 3);
         end
         pack_delays();
         do_reset();
         wait_end();
         check_good_run(m);
      end

      // R1: mode change after the sequence started is ignored
      for (int i = 0; i < 4; i++) begin rv[i] = 1; sv[i] = 1; end
      pack_delays();
      mode = 3'd2;
      do_reset();
      wait_first();
      mode = 3'd5;
      wait_end();
      check_good_run(2);

      // R11: restart while sequencing and while done
      mode = 3'd1;
      do_reset();
      wait_first();
      restart = 1'b1;
      step_n();
      restart = 1'b0;
      chk(rail_en == 4'b0001 && busy && !fail, "R11 restart while busy", int'(rail_en), 1);
      wait_end();
      check_good_run(1);
      restart = 1'b1;
      step_n();
      restart = 1'b0;
      step_n();
      chk(rail_en == 4'hF && done && !fail, "R11 restart while done", int'(rail_en), 15);

      // R9: runtime fault while done
      fault = 4'b0110;
      step_n();
      chk(rail_en == 4'h0 && fail && fail_rail == 2'd1, "R9 fault when done",
          int'(fail_rail), 1);
      fault = 4'h0;

      // R10: hold then restart
      repeat (100) step_n();
      chk(fail && fail_rail == 2'd1 && rail_en == 4'h0, "R10 fail held", int'(fail_rail), 1);
      restart = 1'b1;
      step_n();
      restart = 1'b0;
      chk(rail_en == 4'hF && done && !fail && fail_rail == 2'd0 && !busy,
          "R10 restart all on", int'(rail_en), 15);

      // R5: tick held low stalls timing
      do_reset();
      wait_first();
      tick = 1'b0;
      repeat (300) step_n();
      chk(rail_en == 4'b0001, "R5 frozen while tick low", int'(rail_en), 1);
      tick = 1'b1;
      wait_end();
      chk(t_en[1] - t_en[0] == 2 * TPM + 3 + 300, "R5 stall spacing",
          t_en[1] - t_en[0], 2 * TPM + 3 + 300);
      chk(done, "R5 completes after stall", int'(done), 1);

      // R6: clamping of low and high delay values
      rv[0] = 0;
      pack_delays();
      do_reset();
      wait_end();
      chk(t_en[1] - t_en[0] == TPM + TPM + 3, "R6 zero delay", t_en[1] - t_en[0], 2 * TPM + 3);
      rv[0] = 2000;
      pack_delays();
      do_reset();
      wait_end();
      chk(t_en[1] - t_en[0] == 1300 * TPM + TPM + 3, "R6 high delay",
          t_en[1] - t_en[0], 1300 * TPM + TPM + 3);
      check_good_run(1);
      rv[0] = 1;
      pack_delays();

      // R8, R3: power-good low at each step of mode 4
      mode = 3'd4;
      for (int s = 0; s < 4; s++) begin
         int r;
         r = exp_rail(4, s);
         pgood = 4'hF & ~(4'b0001 << r);
         do_reset();
         wait_end();
         chk(fail && rail_en == 4'h0 && fail_rail == 2'(r), "R8 fail rail",
             int'(fail_rail), r);
         chk(t_fail - t_en[r] == TPM + 1, "R8 check timing", t_fail - t_en[r], TPM + 1);
         chk(n_seen == s + 1, "R3 no later rail enabled", n_seen, s + 1);
         chk(!busy && !done, "R8 idle flags", int'(busy), 0);
      end
      pgood = 4'hF;

      // R9: fault during a ramp delay
      mode = 3'd1;
      do_reset();
      wait_first();
      fault = 4'b1000;
      step_n();
      chk(fail && fail_rail == 2'd3 && rail_en == 4'h0, "R9 fault during ramp",
          int'(fail_rail), 3);
      fault = 4'h0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule